// File: doc/BRIEF.md
# Serial HDLC Frame Receiver with Station Address Filter

This block takes a serial bit stream, qualified by a per-bit enable, and recovers HDLC frames from it. It finds the flag octet that opens and closes each frame, removes the zero bits the sender inserted after runs of five ones, packs the remaining bits into bytes (least significant bit first), and checks the 16-bit frame check sequence. Each data byte of an accepted frame is delivered to a receive buffer as a one-cycle strobe with its data. The last data byte carries an end-of-frame tag, and a bad-check tag when the check fails. The two check bytes themselves are never delivered.

An optional station filter looks at the first byte of every frame. In byte mode the filter compares the whole byte. In seven-bit mode it compares the upper seven bits, and bit 0 must be set. Frames that fail the filter leave no trace at the output. Turning reception off lets a frame already under way finish. A buffer-clear strobe marks the buffer empty, drops the frame under way, and keeps the receiver silent until a flag is seen again.

Top module: `hdlc_addr_rx`

## Requirements
- R1: After reset, `out_valid`, `out_eof` and `out_badcrc` are 0 and `buf_empty` is 1. Filtering and reception are off, so a complete frame sent while `rx_enable` is 0 produces no output.
- R2: A frame is opened and closed by the flag 0x7E. A zero that follows five ones is removed. Bytes are built least significant bit first, and every data byte is output in order, `out_valid` high for one cycle per byte.
- R3: The check is CRC-16 with reflected polynomial 0x8408 and seed 0xFFFF, run over all bytes including the two check bytes. The sender transmits the one's complement of the register, low byte first. On a residue of 0xF0B8, the last data byte is output with `out_eof`=1 and `out_badcrc`=0; otherwise it is output with `out_eof`=1 and `out_badcrc`=1. `out_badcrc` is never 1 without `out_eof`, and neither tag is 1 without `out_valid`.
- R4: A frame of fewer than 4 bytes between flags, check bytes included, produces no output. A frame of exactly 4 bytes produces its 2 data bytes.
- R5: With `filt_en`=1 and `seven_mode`=0, a frame is output only if its first byte equals `station_addr` or 0xFF.
- R6: With `filt_en`=1 and `seven_mode`=1, a frame is output only if bit 0 of its first byte is 1 and bits 7:1 equal either `station_addr[7:1]` or 7'h7F.
- R7: With `filt_en`=0, every frame of valid length is output whatever its first byte.
- R8: Seven or more ones in a row abort the frame. If bytes of the frame have already been output, one more byte is output with `out_eof`=1 and `out_badcrc`=1. Otherwise the abort produces nothing.
- R9: Dropping `rx_enable` after the first byte of a frame is complete lets that frame finish normally. After that frame ends, no further frames are output while `rx_enable` stays 0.
- R10: A line bit is taken only in a cycle with `bit_en`=1. Any number of `bit_en`=0 cycles between bits leaves the result unchanged, and `out_valid` rises only in the cycle after a `bit_en`=1 cycle.
- R11: A one-cycle `fifo_rst` sets `buf_empty` to 1 in the next cycle and drops the frame in progress. No byte of that frame, nor its closing flag, produces output. The next frame after a flag is received normally.
- R12: `buf_empty` goes to 0 in the same cycle in which a byte is output, and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| rx_enable | input | 1 | Reception on; turning it off takes effect at frame end |
| filt_en | input | 1 | Station address filter on |
| seven_mode | input | 1 | Compare the address on bits 7:1 and require bit 0 = 1 |
| station_addr | input | 8 | Programmed station address |
| fifo_rst | input | 1 | Buffer-clear strobe |
| out_valid | output | 1 | One-cycle byte strobe into the buffer |
| out_data | output | 8 | Received data byte |
| out_eof | output | 1 | Byte is the last of its frame |
| out_badcrc | output | 1 | Frame failed its check or was aborted |
| buf_empty | output | 1 | Buffer holds no byte since the last clear |

## Verification
On every cycle the assertions check the following:
- The two tags only ever appear on a delivered byte, and the bad-check tag only on a final byte.
- A byte can only follow a cycle that carried a qualified line bit.
- A buffer clear is followed by an empty buffer and no byte.
- The empty flag falls only together with a delivered byte.

Only the bench's scenarios can show the rest: that the bytes are the right ones, that stuffing and the check sequence are handled, which addresses pass the filter in each mode, the length limit, the outcome of an abort, late disabling and the silence after a clear.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_W     = $clog2(BYTE_W);
    localparam int CRC_W     = 16;
    localparam int MIN_FRAME = 4;
    localparam int HOLD_N    = 3;
    localparam int CNT_W     = $clog2(MIN_FRAME + 1);
    localparam int RUN_W     = 3;

    localparam logic [CRC_W-1:0] CRC_POLY_REF = 16'h8408;
    localparam logic [CRC_W-1:0] CRC_SEED     = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_GOOD     = 16'hF0B8;

    typedef enum logic [1:0] {EV_DATA, EV_SKIP, EV_FLAG, EV_ABORT} bit_ev_e;
    typedef enum logic [1:0] {ST_OFF, ST_HUNT, ST_FRAME} rx_st_e;

    typedef struct packed {
        rx_st_e                         st;
        logic [BYTE_W-1:0]              sh;
        logic [BIT_W-1:0]               bitcnt;
        logic [CNT_W-1:0]               nbytes;
        logic [CRC_W-1:0]               crc;
        logic [HOLD_N-1:0][BYTE_W-1:0]  hold;
        logic                           acc;
        logic                           emitted;
        logic                           ov;
        logic [BYTE_W-1:0]              od;
        logic                           oeof;
        logic                           obad;
        logic                           empty;
    } rx_state_t;

    // Bitwise update of the reflected CRC over one byte, LSB first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REF;
            else             r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/hdlc_bit_decoder.sv
module hdlc_bit_decoder
    import hdlc_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  logic    bit_en,
    input  logic    bit_in,
    output logic    ev_valid,
    output bit_ev_e ev_kind
);
    localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(5);
    localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(6);
    localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(7);

    logic [RUN_W-1:0] ones_d, ones_q;

    always_comb begin
        ones_d   = ones_q;
        ev_valid = 1'b0;
        ev_kind  = EV_DATA;
        if (clear) begin
            ones_d = '0;
        end else if (bit_en) begin
            ev_valid = 1'b1;
            if (bit_in) begin
                if (ones_q == RUN_MAX) begin
                    ev_kind = EV_SKIP;
                end else if (ones_q == RUN_FLAG) begin
                    ev_kind = EV_ABORT;
                    ones_d  = RUN_MAX;
                end else begin
                    ev_kind = EV_DATA;
                    ones_d  = ones_q + 1'b1;
                end
            end else begin
                ones_d = '0;
                if (ones_q == RUN_FLAG)       ev_kind = EV_FLAG;
                else if (ones_q == RUN_STUFF) ev_kind = EV_SKIP;
                else                          ev_kind = EV_DATA;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ones_q <= '0;
        else        ones_q <= ones_d;
    end
endmodule

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match
    import hdlc_rx_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] station,
    input  logic              seven_mode,
    output logic              hit
);
    localparam logic [BYTE_W-1:0] ALL_CALL = '1;

    always_comb begin
        if (seven_mode)
            hit = rx_byte[0] && ((rx_byte[BYTE_W-1:1] == station[BYTE_W-1:1]) ||
                                 (rx_byte[BYTE_W-1:1] == ALL_CALL[BYTE_W-1:1]));
        else
            hit = (rx_byte == station) || (rx_byte == ALL_CALL);
    end
endmodule

// File: rtl/hdlc_addr_rx.sv
module hdlc_addr_rx
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              rx_enable,
    input  logic              filt_en,
    input  logic              seven_mode,
    input  logic [BYTE_W-1:0] station_addr,
    input  logic              fifo_rst,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_eof,
    output logic              out_badcrc,
    output logic              buf_empty
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] EMIT_AT  = CNT_W'(MIN_FRAME - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_FRAME);

    rx_state_t          q, d;
    logic               dec_clear, ev_valid, addr_hit;
    bit_ev_e            ev_kind;
    logic [BYTE_W-1:0]  new_byte;

    assign dec_clear = (q.st == ST_OFF) || fifo_rst;
    assign new_byte  = {bit_in, q.sh[BYTE_W-1:1]};

    hdlc_bit_decoder u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (dec_clear),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind)
    );

    hdlc_addr_match u_match (
        .rx_byte    (new_byte),
        .station    (station_addr),
        .seven_mode (seven_mode),
        .hit        (addr_hit)
    );

    always_comb begin
        d      = q;
        d.ov   = 1'b0;
        d.oeof = 1'b0;
        d.obad = 1'b0;
        if (fifo_rst) begin
            d.st      = rx_enable ? ST_HUNT : ST_OFF;
            d.empty   = 1'b1;
            d.nbytes  = '0;
            d.bitcnt  = '0;
            d.acc     = 1'b0;
            d.emitted = 1'b0;
        end else begin
            case (q.st)
                ST_OFF: begin
                    if (rx_enable) d.st = ST_HUNT;
                end
                ST_HUNT: begin
                    if (!rx_enable) begin
                        d.st = ST_OFF;
                    end else if (ev_valid && ev_kind == EV_FLAG) begin
                        d.st      = ST_FRAME;
                        d.bitcnt  = '0;
                        d.nbytes  = '0;
                        d.crc     = CRC_SEED;
                        d.acc     = 1'b0;
                        d.emitted = 1'b0;
                    end
                end
                ST_FRAME: begin
                    if (ev_valid) begin
                        case (ev_kind)
                            EV_DATA: begin
                                d.sh     = new_byte;
                                d.bitcnt = q.bitcnt + 1'b1;
                                if (q.bitcnt == LAST_BIT) begin
                                    d.crc = crc_step(q.crc, new_byte);
                                    if (q.nbytes == '0) d.acc = !filt_en || addr_hit;
                                    if (q.nbytes < CNT_SAT) d.nbytes = q.nbytes + 1'b1;
                                    for (int k = HOLD_N - 1; k > 0; k--)
                                        d.hold[k] = q.hold[k-1];
                                    d.hold[0] = new_byte;
                                    if (q.nbytes >= EMIT_AT && q.acc) begin
                                        d.ov      = 1'b1;
                                        d.od      = q.hold[HOLD_N-1];
                                        d.empty   = 1'b0;
                                        d.emitted = 1'b1;
                                    end
                                end
                            end
                            EV_FLAG: begin
                                if (q.emitted) begin
                                    d.ov    = 1'b1;
                                    d.od    = q.hold[HOLD_N-1];
                                    d.oeof  = 1'b1;
                                    d.obad  = (q.bitcnt != LAST_BIT) || (q.crc != CRC_GOOD);
                                    d.empty = 1'b0;
                                end
                                d.bitcnt  = '0;
                                d.nbytes  = '0;
                                d.crc     = CRC_SEED;
                                d.acc     = 1'b0;
                                d.emitted = 1'b0;
                            end
                            EV_ABORT: begin
                                if (q.emitted) begin
                                    d.ov    = 1'b1;
                                    d.od    = q.hold[HOLD_N-1];
                                    d.oeof  = 1'b1;
                                    d.obad  = 1'b1;
                                    d.empty = 1'b0;
                                end
                                d.st      = ST_HUNT;
                                d.nbytes  = '0;
                                d.acc     = 1'b0;
                                d.emitted = 1'b0;
                            end
                            default: ;
                        endcase
                    end
                    if (!rx_enable && d.st == ST_FRAME && d.nbytes == '0)
                        d.st = ST_OFF;
                end
                default: d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_OFF, sh: '0, bitcnt: '0, nbytes: '0, crc: CRC_SEED,
                   hold: '0, acc: 1'b0, emitted: 1'b0, ov: 1'b0, od: '0,
                   oeof: 1'b0, obad: 1'b0, empty: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign out_valid  = q.ov;
    assign out_data   = q.od;
    assign out_eof    = q.oeof;
    assign out_badcrc = q.obad;
    assign buf_empty  = q.empty;
endmodule

// File: rtl/hdlc_addr_rx_chk.sv
module hdlc_addr_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic fifo_rst,
    input logic out_valid,
    input logic out_eof,
    input logic out_badcrc,
    input logic buf_empty
);
    // R3: the bad-check tag only ever marks a final byte
    p_bad_needs_eof_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_badcrc |-> out_eof);

    // R3: no tag without a delivered byte
    p_tags_need_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_eof && !out_badcrc));

    // R10: a byte only follows a qualified line bit
    p_byte_after_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(bit_en));

    // R11: a clear empties the buffer and suppresses output
    p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst |=> (buf_empty && !out_valid));

    // R12: empty flag is low whenever a byte is delivered
    p_byte_not_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !buf_empty);

    // R12: the empty flag falls only with a byte
    p_empty_falls_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_empty) |-> out_valid);
endmodule

bind hdlc_addr_rx hdlc_addr_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .fifo_rst   (fifo_rst),
    .out_valid  (out_valid),
    .out_eof    (out_eof),
    .out_badcrc (out_badcrc),
    .buf_empty  (buf_empty)
);

// File: tb/tb_hdlc_addr_rx.sv
`timescale 1ns/1ps
module tb_hdlc_addr_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, bit_in = 1'b0;
    logic       rx_enable = 1'b0, filt_en = 1'b0, seven_mode = 1'b0;
    logic [7:0] station_addr = 8'h00;
    logic       fifo_rst = 1'b0;
    logic       out_valid, out_eof, out_badcrc, buf_empty;
    logic [7:0] out_data;

    int         n_tests = 0, n_fail = 0;
    int         ncap = 0;
    logic [9:0] cap [0:255];
    logic [7:0] fr [0:7];
    int         ones_tx = 0;
    int         gap_n = 0;
    logic [15:0] crc_tx = 16'hFFFF;

    always #4 clk = ~clk;

    hdlc_addr_rx dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .rx_enable(rx_enable), .filt_en(filt_en), .seven_mode(seven_mode),
        .station_addr(station_addr), .fifo_rst(fifo_rst),
        .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof),
        .out_badcrc(out_badcrc), .buf_empty(buf_empty)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            cap[ncap[7:0]] <= {out_badcrc, out_eof, out_data};
            ncap <= ncap + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ b[i];
            r = r >> 1;
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    task automatic put_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        for (int g = 0; g < gap_n; g++) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = ~b;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bit_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic put_flag();
        logic [7:0] f = 8'h7E;
        for (int i = 0; i < 8; i++) put_bit(f[i]);
        ones_tx = 0;
    endtask

    task automatic put_ones(input int n);
        for (int i = 0; i < n; i++) put_bit(1'b1);
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            put_bit(b[i]);
            if (b[i]) begin
                ones_tx++;
                if (ones_tx == 5) begin
                    put_bit(1'b0);
                    ones_tx = 0;
                end
            end else begin
                ones_tx = 0;
            end
        end
    endtask

    task automatic put_open();
        put_flag();
        crc_tx = 16'hFFFF;
    endtask

    task automatic put_payload(input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            put_byte(fr[i]);
            crc_tx = crc_upd(crc_tx, fr[i]);
        end
    endtask

    task automatic put_close(input bit corrupt);
        logic [15:0] fcs = ~crc_tx;
        if (corrupt) fcs[3] = ~fcs[3];
        put_byte(fcs[7:0]);
        put_byte(fcs[15:8]);
        put_flag();
        put_flag();
        idle(3);
    endtask

    task automatic send_frame(input int d, input bit corrupt);
        put_open();
        put_payload(0, d);
        put_close(corrupt);
    endtask

    task automatic expect_frame(input int start, input int d, input bit bad, input string tag);
        check(ncap - start == d, {tag, " byte count"}, ncap - start, d);
        for (int k = 0; k < d && k < ncap - start; k++) begin
            logic [9:0] e;
            e = {(k == d - 1) && bad, k == d - 1, fr[k]};
            check(cap[(start + k) % 256] == e, {tag, " byte/tags"}, cap[(start + k) % 256], e);
        end
    endtask

    task automatic expect_none(input int start, input string tag);
        check(ncap == start, {tag, " no output"}, ncap - start, 0);
    endtask

    task automatic load(input logic [7:0] a, b, c, d, e, f);
        fr[0] = a; fr[1] = b; fr[2] = c; fr[3] = d; fr[4] = e; fr[5] = f;
    endtask

    task automatic t_reset();
        check(out_valid == 0 && out_eof == 0 && out_badcrc == 0, "R1 outputs idle", out_valid, 0);
        check(buf_empty == 1, "R1 buffer empty", buf_empty, 1);
    endtask

    task automatic t_off_after_reset();
        int s = ncap;
        load(8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00);
        send_frame(3, 0);
        expect_none(s, "R1 reception off");
        check(buf_empty == 1, "R1 still empty", buf_empty, 1);
    endtask

    task automatic t_good();
        int s;
        filt_en = 0;
        load(8'h5A, 8'h03, 8'hFF, 8'h7E, 8'h3E, 8'hC1);
        s = ncap; send_frame(6, 0);
        expect_frame(s, 6, 0, "R2 R7 stuffed frame");
        check(buf_empty == 0, "R12 not empty", buf_empty, 0);
        load(8'h00, 8'hFC, 8'h1F, 8'h00, 8'h00, 8'h00);
        s = ncap; send_frame(3, 0);
        expect_frame(s, 3, 0, "R2 second pattern");
    endtask

    task automatic t_badcrc();
        int s;
        load(8'hA5, 8'h11, 8'h22, 8'h33, 8'h00, 8'h00);
        s = ncap; send_frame(4, 1);
        expect_frame(s, 4, 1, "R3 corrupted check");
    endtask

    task automatic t_short();
        int s;
        load(8'h44, 8'h55, 8'h00, 8'h00, 8'h00, 8'h00);
        s = ncap; send_frame(1, 0);
        expect_none(s, "R4 three-byte frame");
        s = ncap; send_frame(2, 0);
        expect_frame(s, 2, 0, "R4 four-byte frame");
    endtask

    task automatic run_addr(input logic [7:0] a, input bit accept, input string tag);
        int s = ncap;
        load(a, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00);
        send_frame(3, 0);
        if (accept) expect_frame(s, 3, 0, tag);
        else        expect_none(s, tag);
    endtask

    task automatic t_filter8();
        filt_en = 1; seven_mode = 0; station_addr = 8'h5A;
        run_addr(8'h5A, 1, "R5 own address");
        run_addr(8'hFF, 1, "R5 all-call");
        run_addr(8'h5B, 0, "R5 other address");
        run_addr(8'h7F, 0, "R5 seven-bit all-call in byte mode");
    endtask

    task automatic t_filter7();
        filt_en = 1; seven_mode = 1; station_addr = 8'h5A;
        run_addr(8'h5B, 1, "R6 own address bit0 set");
        run_addr(8'h5A, 0, "R6 bit0 clear");
        run_addr(8'hFF, 1, "R6 all-call");
        run_addr(8'h7B, 0, "R6 other address");
        filt_en = 0; seven_mode = 0;
        run_addr(8'h5A, 1, "R7 filter off");
    endtask

    task automatic t_abort();
        int s;
        load(8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h00);
        s = ncap;
        put_open(); put_payload(0, 5); put_ones(8); put_flag(); idle(3);
        expect_frame(s, 3, 1, "R8 abort after delivery");
        s = ncap;
        put_open(); put_payload(0, 2); put_ones(8); put_flag(); idle(3);
        expect_none(s, "R8 abort before delivery");
    endtask

    task automatic t_gaps();
        int s;
        gap_n = 3;
        load(8'h81, 8'hF8, 8'h3F, 8'h00, 8'h00, 8'h00);
        s = ncap; send_frame(3, 0);
        expect_frame(s, 3, 0, "R10 gapped bits");
        gap_n = 0;
    endtask

    task automatic t_disable();
        int s;
        load(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h00);
        s = ncap;
        put_open(); put_payload(0, 3);
        @(negedge clk); bit_en = 1'b0; rx_enable = 1'b0;
        put_payload(3, 5); put_close(0);
        expect_frame(s, 5, 0, "R9 frame finishes");
        s = ncap; send_frame(5, 0);
        expect_none(s, "R9 idle after disable");
        rx_enable = 1'b1;
        idle(2);
    endtask

    task automatic t_fifo_rst();
        int s;
        load(8'h21, 8'h43, 8'h65, 8'h87, 8'hA9, 8'h00);
        put_open(); put_payload(0, 5);
        @(negedge clk); bit_en = 1'b0; fifo_rst = 1'b1;
        @(negedge clk); fifo_rst = 1'b0;
        check(buf_empty == 1, "R11 empty after clear", buf_empty, 1);
        s = ncap;
        put_close(0);
        expect_none(s, "R11 dropped frame");
        s = ncap; send_frame(4, 0);
        expect_frame(s, 4, 0, "R11 next frame");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off_after_reset();
        rx_enable = 1'b1;
        idle(2);
        t_good();
        t_badcrc();
        t_short();
        t_filter8();
        t_filter7();
        t_abort();
        t_gaps();
        t_disable();
        t_fifo_rst();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule